// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block holds the operating mode of a processor subsystem. There is one normal mode and four low-power modes: doze, sleep, deep-sleep and power-down. Software programs a small mode register. That register has a 2-bit mode field, a power-down request bit, a clock-source field and a frequency-select bit. The block decides which of these writes may change anything in the current mode. A single exit event returns the block from any low-power mode to normal operation.

Normal and doze each run in a high or a low frequency sub-state. The `freq_lo_o` output shows the sub-state. The block also forwards the matching one of two programmable divisor values to the clock divider. The divider itself, peripheral clock gating and the logic that produces the wake event are not part of the block.

Top module: `lpm_seq`

## Requirements
- R1: After reset, `mode_o` is 0 (normal), `freq_lo_o` is 0 (high sub-state), `lpm_fld_o` is 00, `pdn_fld_o` is 0 and `csrc_o` is 0.
- R2: `mode_o` uses this encoding: 0 normal, 1 doze, 2 sleep, 3 deep-sleep, 4 power-down. The mode field uses 00 normal, 01 doze, 10 sleep and 11 deep-sleep. When the accepted write has `wr_pdn` set to 1, the target is power-down, whatever the field value.
- R3: In normal mode, with low-power modes enabled, a write (`wr_en`=1) stores `wr_mode` and `wr_pdn`. `mode_o` shows the target on the cycle after the write.
- R4: Low-power modes are enabled only when `cpu_pwr_en`=1 and `lp_lock`=0. Otherwise a write leaves `mode_o`, `lpm_fld_o` and `pdn_fld_o` unchanged. The clock-source and frequency-select parts of that write still take effect in normal mode.
- R5: Outside normal mode, a write never changes `mode_o`. Only the exit event leaves a low-power mode.
- R6: In doze, a write leaves `csrc_o`, `lpm_fld_o` and `pdn_fld_o` unchanged. The frequency-select bit `wr_flo` is still written, so doze can switch between its high and low sub-states.
- R7: In sleep, deep-sleep and power-down, a write changes no output.
- R8: On the cycle after `wake_i`=1, the block is in normal-high: `mode_o`=0, `freq_lo_o`=0, `lpm_fld_o`=00 and `pdn_fld_o`=0. `csrc_o` keeps its value. The exit takes priority over a write in the same cycle.
- R9: `div_o` equals `div_lo` while `freq_lo_o`=1 and equals `div_hi` while it is 0, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_pwr_en | input | 1 | Processor power-management enable |
| lp_lock | input | 1 | Low-power lock; 1 blocks mode entry |
| wake_i | input | 1 | Low-power exit event |
| wr_en | input | 1 | Write strobe for the mode register |
| wr_mode | input | 2 | Mode field write data |
| wr_pdn | input | 1 | Power-down request write data |
| wr_csrc | input | CSRC_W | Clock-source field write data |
| wr_flo | input | 1 | Frequency-select write data (1 = low) |
| div_hi | input | DIV_W | High-frequency divisor value |
| div_lo | input | DIV_W | Low-frequency divisor value |
| mode_o | output | 3 | Current operating mode |
| freq_lo_o | output | 1 | Low frequency sub-state active |
| lpm_fld_o | output | 2 | Stored mode field |
| pdn_fld_o | output | 1 | Stored power-down request |
| csrc_o | output | CSRC_W | Stored clock-source field |
| div_o | output | DIV_W | Selected divisor |

## Verification
Every piece of state in the block is visible at a port, so a wrong internal value shows up on the very next clock edge.

A wrongly accepted write appears on `mode_o` or on a stored field one cycle after the write. A lost exit event leaves `mode_o` non-zero in the cycle after `wake_i`. A wrong sub-state shows on `freq_lo_o` and, in the same cycle, on `div_o`.

Because of this, comparing the ports against a reference model on every cycle, across directed and random stimulus, finds any divergence within one clock.

// File: rtl/lpm_seq.sv
module lpm_seq #(
  parameter int CSRC_W = 2,
  parameter int DIV_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_pwr_en,
  input  logic              lp_lock,
  input  logic              wake_i,
  input  logic              wr_en,
  input  logic [1:0]        wr_mode,
  input  logic              wr_pdn,
  input  logic [CSRC_W-1:0] wr_csrc,
  input  logic              wr_flo,
  input  logic [DIV_W-1:0]  div_hi,
  input  logic [DIV_W-1:0]  div_lo,
  output logic [2:0]        mode_o,
  output logic              freq_lo_o,
  output logic [1:0]        lpm_fld_o,
  output logic              pdn_fld_o,
  output logic [CSRC_W-1:0] csrc_o,
  output logic [DIV_W-1:0]  div_o
);

  localparam logic [2:0] M_NORM = 3'd0;
  localparam logic [2:0] M_DOZE = 3'd1;
  localparam logic [2:0] M_PDN  = 3'd4;

  logic [2:0]        st_q;
  logic              flo_q;
  logic [1:0]        fld_q;
  logic              pdn_q;
  logic [CSRC_W-1:0] csrc_q;

  wire lp_ok   = cpu_pwr_en & ~lp_lock;
  wire in_norm = (st_q == M_NORM);
  wire in_doze = (st_q == M_DOZE);
  wire wr_ok   = wr_en & ~wake_i;
  wire mode_wr = wr_ok & in_norm & lp_ok;
  wire [2:0] target = wr_pdn ? M_PDN : {1'b0, wr_mode};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= M_NORM;
      flo_q  <= 1'b0;
      fld_q  <= 2'b00;
      pdn_q  <= 1'b0;
      csrc_q <= '0;
    end else if (wake_i) begin
      st_q  <= M_NORM;
      flo_q <= 1'b0;
      fld_q <= 2'b00;
      pdn_q <= 1'b0;
    end else begin
      if (wr_ok && (in_norm || in_doze)) flo_q <= wr_flo;
      if (wr_ok && in_norm) csrc_q <= wr_csrc;
      if (mode_wr) begin
        fld_q <= wr_mode;
        pdn_q <= wr_pdn;
        st_q  <= target;
      end
    end
  end

  assign mode_o    = st_q;
  assign freq_lo_o = flo_q;
  assign lpm_fld_o = fld_q;
  assign pdn_fld_o = pdn_q;
  assign csrc_o    = csrc_q;
  assign div_o     = flo_q ? div_lo : div_hi;

  assert_legal_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o <= M_PDN);

  assert_exit_normal_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_i |=> (mode_o == M_NORM && !freq_lo_o && lpm_fld_o == 2'b00 && !pdn_fld_o));

  assert_exit_keeps_csrc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_i |=> $stable(csrc_o));

  assert_locked_no_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wake_i && !(cpu_pwr_en && !lp_lock)) |=> ($stable(mode_o) && $stable(lpm_fld_o)));

  assert_only_from_normal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != M_NORM && !wake_i) |=> $stable(mode_o));

  assert_doze_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == M_DOZE && !wake_i) |=> ($stable(csrc_o) && $stable(lpm_fld_o) && $stable(pdn_fld_o)));

  assert_deep_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o >= 3'd2 && !wake_i) |=> ($stable(freq_lo_o) && $stable(csrc_o)));

  assert_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == M_NORM && wr_en && !wake_i && cpu_pwr_en && !lp_lock && !wr_pdn) |=> (mode_o == {1'b0, $past(wr_mode)}));

  always_comb begin
    assert_div_sel_R9: assert (div_o == (freq_lo_o ? div_lo : div_hi));
  end

endmodule

// File: tb/lpm_seq_tb.sv
`timescale 1ns/1ps
module lpm_seq_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic cpu_pwr_en = 0, lp_lock = 0, wake_i = 0, wr_en = 0, wr_pdn = 0, wr_flo = 0;
  logic [1:0] wr_mode = 0, wr_csrc = 0;
  logic [3:0] div_hi = 4'h3, div_lo = 4'hc;
  logic [2:0] mode_o;
  logic freq_lo_o, pdn_fld_o;
  logic [1:0] lpm_fld_o, csrc_o;
  logic [3:0] div_o;

  int checks = 0, failures = 0;
  string phase = "R1";
  int m_st = 0, m_flo = 0, m_fld = 0, m_pdn = 0, m_cs = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lpm_seq #(.CSRC_W(2), .DIV_W(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_pwr_en(cpu_pwr_en), .lp_lock(lp_lock),
    .wake_i(wake_i), .wr_en(wr_en), .wr_mode(wr_mode), .wr_pdn(wr_pdn),
    .wr_csrc(wr_csrc), .wr_flo(wr_flo), .div_hi(div_hi), .div_lo(div_lo),
    .mode_o(mode_o), .freq_lo_o(freq_lo_o), .lpm_fld_o(lpm_fld_o),
    .pdn_fld_o(pdn_fld_o), .csrc_o(csrc_o), .div_o(div_o));

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  // Reference model: behaviour taken from the requirements
  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_flo = 0; m_fld = 0; m_pdn = 0; m_cs = 0;
    end else if (wake_i) begin
      m_st = 0; m_flo = 0; m_fld = 0; m_pdn = 0;
    end else if (wr_en) begin
      if (m_st == 0) begin
        m_cs = wr_csrc; m_flo = wr_flo;
        if (cpu_pwr_en && !lp_lock) begin
          m_fld = wr_mode; m_pdn = wr_pdn;
          m_st = wr_pdn ? 4 : wr_mode;
        end
      end else if (m_st == 1) begin
        m_flo = wr_flo;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(phase, "mode", mode_o, m_st);
      chk(phase, "freq_lo", freq_lo_o, m_flo);
      chk(phase, "fld", lpm_fld_o, m_fld);
      chk(phase, "pdn", pdn_fld_o, m_pdn);
      chk(phase, "csrc", csrc_o, m_cs);
      chk("R9", "div", div_o, m_flo ? div_lo : div_hi);
    end
  end

  task automatic wr(input int md, input int pd, input int cs, input int fl);
    wr_en = 1; wr_mode = md[1:0]; wr_pdn = pd[0]; wr_csrc = cs[1:0]; wr_flo = fl[0];
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wake();
    wake_i = 1; @(negedge clk); wake_i = 0;
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "reset mode", mode_o, 0);
    chk("R1", "reset freq", freq_lo_o, 0);
    chk("R1", "reset csrc", csrc_o, 0);
    cpu_pwr_en = 1; lp_lock = 0;
    phase = "R3"; wr(1, 0, 2, 0);
    chk("R3", "doze entry", mode_o, 1);
    phase = "R6"; wr(2, 1, 3, 1);
    chk("R6", "doze keeps mode", mode_o, 1);
    chk("R6", "doze low sub", freq_lo_o, 1);
    chk("R6", "doze csrc frozen", csrc_o, 2);
    chk("R9", "low divisor", div_o, 12);
    phase = "R8"; wake();
    chk("R8", "exit mode", mode_o, 0);
    chk("R8", "exit high", freq_lo_o, 0);
    chk("R8", "csrc kept", csrc_o, 2);
    phase = "R4"; cpu_pwr_en = 0; wr(2, 0, 1, 1);
    chk("R4", "no entry pwr", mode_o, 0);
    chk("R4", "csrc written", csrc_o, 1);
    cpu_pwr_en = 1; lp_lock = 1; wr(3, 1, 1, 0);
    chk("R4", "no entry lock", mode_o, 0);
    chk("R4", "fld kept", lpm_fld_o, 0);
    lp_lock = 0;
    phase = "R3"; wr(2, 0, 0, 1);
    chk("R3", "sleep entry", mode_o, 2);
    phase = "R7"; wr(0, 0, 3, 0);
    chk("R7", "sleep frozen mode", mode_o, 2);
    chk("R7", "sleep frozen freq", freq_lo_o, 1);
    phase = "R8"; wake();
    phase = "R3"; wr(3, 0, 0, 0);
    chk("R3", "deep entry", mode_o, 3);
    phase = "R5"; wr(1, 0, 0, 0);
    chk("R5", "no change from deep", mode_o, 3);
    phase = "R8"; wake();
    phase = "R2"; wr(1, 1, 0, 0);
    chk("R2", "pdn overrides field", mode_o, 4);
    chk("R2", "pdn stored", pdn_fld_o, 1);
    phase = "R7"; wr(0, 0, 2, 1);
    chk("R7", "pdn frozen", mode_o, 4);
    phase = "R8"; wake();
    wake_i = 1; wr(2, 0, 1, 1); wake_i = 0;
    chk("R8", "exit beats write", mode_o, 0);
    chk("R8", "exit beats csrc", csrc_o, 0);
    phase = "R5";
    for (int i = 0; i < 2000; i++) begin
      cpu_pwr_en = $urandom % 4 != 0;
      lp_lock = $urandom % 4 == 0;
      wake_i = $urandom % 8 == 0;
      wr_en = $urandom % 2;
      wr_mode = 2'($urandom); wr_pdn = $urandom % 5 == 0;
      wr_csrc = 2'($urandom); wr_flo = 1'($urandom);
      div_hi = 4'($urandom); div_lo = 4'($urandom);
      @(negedge clk);
    end
    wake_i = 0; wr_en = 0;
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule